// File: doc/BRIEF.md
# Lockable Encryption Region Register File

This block is the configuration register bank that sits beside an on-the-fly memory encryption engine. Software uses a simple word-addressed bus to set a global encryption enable, a 64-bit mask that is applied to decrypted data, and a base address, a sub-region enable word and a 64-bit initialisation vector for each of three regions. All of these values are driven continuously on output ports so the encryption datapath can use them.

A lock register protects the configuration. It has one bit per region group and one bit for the data mask. Once a lock bit is set it stays set until reset. After that, writes to the protected registers are dropped without any response, while reads still return the stored contents. An error register records accesses to addresses that hold no register. Software clears it by writing zero.

Word addresses: 0x00 enable, 0x01 mask low word, 0x02 mask high word, 0x03 lock, 0x04 error. Region r occupies 0x10+4r to 0x13+4r, with the fields in the order base, sub-region enable, IV low word, IV high word.

Top module: `enc_regs`

## Requirements
- R1: After reset every register reads zero and every configuration output, including the lock bits, is zero.
- R2: Address 0x00 holds the encryption enable in bit 0. It drives `enc_en` and reads back as written, with bits 31:1 reading zero.
- R3: Address 0x01 holds the low word and 0x02 the high word of the data mask. `data_mask` is {high, low}, and both words read back.
- R4: Region r has its base at 0x10+4r, its sub-region enable at 0x11+4r, its IV low word at 0x12+4r and its IV high word at 0x13+4r. Each field reads back and drives its slice r of the matching output.
- R5: At address 0x03, lock bit r (r = 0..2) guards region r and bit 8 guards the mask. Only those bits of a write take effect. Bits 9 and above and bits 3..7 are discarded and read zero.
- R6: Lock bits are sticky: writing zero or any other value never clears a set lock bit before reset.
- R7: A write to any field of a locked region leaves it unchanged, and reads still return the stored value. Unlocked regions stay writable.
- R8: A write to either mask word while bit 8 is locked leaves `data_mask` and the read values unchanged.
- R9: A read of an address that holds no register (including 0x05..0x0F, 0x1C and above) returns zero and sets error bit 0.
- R10: A write to an address that holds no register changes no register and sets error bit 0.
- R11: Writing zero to the error register at 0x04 clears it. Writing a nonzero value leaves it unchanged.
- R12: `rd_data` is updated on the clock edge that samples `rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| enc_en | output | 1 | Global encryption enable |
| data_mask | output | 64 | Data mask {high, low} |
| lock_bits | output | 9 | Lock register contents |
| region_base | output | 96 | Region base addresses, region r in bits 32r+31:32r |
| region_sren | output | 96 | Region sub-region enable words |
| region_iv | output | 192 | Region IVs, region r in bits 64r+63:64r |

## Verification
A write is captured on the edge that samples `wr_en`. The configuration outputs and the lock bits therefore change one edge after the strobe, and the bench samples them at the falling edge that follows. A read result appears in `rd_data` on the edge that samples `rd_en`, so each read check samples half a cycle after that edge and never earlier. Error-register effects are checked with a later read, one full access after the access that caused them. The hold property of `rd_data` is checked over several idle cycles after a read.

// File: rtl/enc_regs_pkg.sv
package enc_regs_pkg;

    localparam logic [7:0] A_EN       = 8'h00;
    localparam logic [7:0] A_MASK_LO  = 8'h01;
    localparam logic [7:0] A_MASK_HI  = 8'h02;
    localparam logic [7:0] A_LOCK     = 8'h03;
    localparam logic [7:0] A_ERR      = 8'h04;
    localparam logic [7:0] A_REG_BASE = 8'h10;

    localparam int LOCK_W        = 9;
    localparam int MASK_LOCK_BIT = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN,
        SEL_MLO,
        SEL_MHI,
        SEL_LOCK,
        SEL_ERR,
        SEL_REG
    } sel_e;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_SREN = 2'd1,
        FLD_IVLO = 2'd2,
        FLD_IVHI = 2'd3
    } fld_e;

endpackage

// File: rtl/enc_regs_dec.sv
module enc_regs_dec
    import enc_regs_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_REGIONS = 3,
    parameter int IDX_W       = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output fld_e              fld,
    output logic [IDX_W-1:0]  ridx
);

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] widx;

    always_comb begin
        offs = addr - ADDR_W'(A_REG_BASE);
        widx = offs >> 2;
        sel  = SEL_NONE;
        fld  = fld_e'(addr[1:0]);
        ridx = '0;
        if (addr == ADDR_W'(A_EN)) begin
            sel = SEL_EN;
        end else if (addr == ADDR_W'(A_MASK_LO)) begin
            sel = SEL_MLO;
        end else if (addr == ADDR_W'(A_MASK_HI)) begin
            sel = SEL_MHI;
        end else if (addr == ADDR_W'(A_LOCK)) begin
            sel = SEL_LOCK;
        end else if (addr == ADDR_W'(A_ERR)) begin
            sel = SEL_ERR;
        end else if (addr >= ADDR_W'(A_REG_BASE) && widx < ADDR_W'(NUM_REGIONS)) begin
            sel  = SEL_REG;
            ridx = IDX_W'(widx);
        end
    end

endmodule

// File: rtl/enc_regs_region.sv
module enc_regs_region
    import enc_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  fld_e                fld,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                locked,
    output logic [DATA_W-1:0]   base,
    output logic [DATA_W-1:0]   sren,
    output logic [2*DATA_W-1:0] iv
);

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] sren;
        logic [DATA_W-1:0] iv_lo;
        logic [DATA_W-1:0] iv_hi;
    } reg_s;

    reg_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr && !locked) begin
            case (fld)
                FLD_BASE: s_d.base  = wdata;
                FLD_SREN: s_d.sren  = wdata;
                FLD_IVLO: s_d.iv_lo = wdata;
                FLD_IVHI: s_d.iv_hi = wdata;
                default:  s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign base = s_q.base;
    assign sren = s_q.sren;
    assign iv   = {s_q.iv_hi, s_q.iv_lo};

endmodule

// File: rtl/enc_regs.sv
module enc_regs
    import enc_regs_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_REGIONS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            enc_en,
    output logic [2*DATA_W-1:0]             data_mask,
    output logic [LOCK_W-1:0]               lock_bits,
    output logic [NUM_REGIONS*DATA_W-1:0]   region_base,
    output logic [NUM_REGIONS*DATA_W-1:0]   region_sren,
    output logic [NUM_REGIONS*2*DATA_W-1:0] region_iv
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam logic [LOCK_W-1:0] LOCK_VALID =
        LOCK_W'(1 << MASK_LOCK_BIT) | LOCK_W'((1 << NUM_REGIONS) - 1);

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] mask_lo;
        logic [DATA_W-1:0] mask_hi;
        logic [LOCK_W-1:0] lock;
        logic [DATA_W-1:0] err;
        logic [DATA_W-1:0] rdata;
    } ctl_s;

    ctl_s c_d, c_q;

    sel_e             sel;
    fld_e             fld;
    logic [IDX_W-1:0] ridx;

    enc_regs_dec #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_dec (
        .addr (addr),
        .sel  (sel),
        .fld  (fld),
        .ridx (ridx)
    );

    logic [DATA_W-1:0]   rb [NUM_REGIONS];
    logic [DATA_W-1:0]   rs [NUM_REGIONS];
    logic [2*DATA_W-1:0] ri [NUM_REGIONS];

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic reg_wr;
        assign reg_wr = wr_en && (sel == SEL_REG) && (ridx == IDX_W'(r));

        enc_regs_region #(
            .DATA_W (DATA_W)
        ) u_region (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (reg_wr),
            .fld    (fld),
            .wdata  (wdata),
            .locked (c_q.lock[r]),
            .base   (rb[r]),
            .sren   (rs[r]),
            .iv     (ri[r])
        );

        assign region_base[r*DATA_W +: DATA_W]     = rb[r];
        assign region_sren[r*DATA_W +: DATA_W]     = rs[r];
        assign region_iv[r*2*DATA_W +: 2*DATA_W]   = ri[r];
    end

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_EN:   rd_val = DATA_W'(c_q.en);
            SEL_MLO:  rd_val = c_q.mask_lo;
            SEL_MHI:  rd_val = c_q.mask_hi;
            SEL_LOCK: rd_val = DATA_W'(c_q.lock);
            SEL_ERR:  rd_val = c_q.err;
            SEL_REG: begin
                case (fld)
                    FLD_BASE: rd_val = rb[ridx];
                    FLD_SREN: rd_val = rs[ridx];
                    FLD_IVLO: rd_val = ri[ridx][DATA_W-1:0];
                    FLD_IVHI: rd_val = ri[ridx][2*DATA_W-1:DATA_W];
                    default:  rd_val = '0;
                endcase
            end
            default:  rd_val = '0;
        endcase
    end

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            case (sel)
                SEL_EN:   c_d.en = wdata[0];
                SEL_MLO:  if (!c_q.lock[MASK_LOCK_BIT]) c_d.mask_lo = wdata;
                SEL_MHI:  if (!c_q.lock[MASK_LOCK_BIT]) c_d.mask_hi = wdata;
                SEL_LOCK: c_d.lock = c_q.lock | (wdata[LOCK_W-1:0] & LOCK_VALID);
                SEL_ERR:  if (wdata == '0) c_d.err = '0;
                SEL_NONE: c_d.err[0] = 1'b1;
                default:  c_d.en = c_q.en;
            endcase
        end
        if (rd_en) begin
            c_d.rdata = rd_val;
            if (sel == SEL_NONE) begin
                c_d.err[0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    logic [DATA_W-1:0] err_q;
    logic              unmapped;

    assign err_q     = c_q.err;
    assign unmapped  = (sel == SEL_NONE);
    assign rd_data   = c_q.rdata;
    assign enc_en    = c_q.en;
    assign data_mask = {c_q.mask_hi, c_q.mask_lo};
    assign lock_bits = c_q.lock;

endmodule

// File: rtl/enc_regs_chk.sv
module enc_regs_chk
    import enc_regs_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_REGIONS = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [DATA_W-1:0]               wdata,
    input logic [DATA_W-1:0]               rd_data,
    input logic                            enc_en,
    input logic [2*DATA_W-1:0]             data_mask,
    input logic [LOCK_W-1:0]               lock_bits,
    input logic [NUM_REGIONS*DATA_W-1:0]   region_base,
    input logic [NUM_REGIONS*DATA_W-1:0]   region_sren,
    input logic [NUM_REGIONS*2*DATA_W-1:0] region_iv,
    input logic [DATA_W-1:0]               err_q,
    input logic                            unmapped
);

    // R2: enable follows bit 0 of a write one edge later
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_EN)) |=> (enc_en == $past(wdata[0])));

    // R6: set lock bits never drop
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_bits & $past(lock_bits)) == $past(lock_bits)));

    // R8: mask frozen while its lock bit is set
    a_r8_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_bits[MASK_LOCK_BIT]) |-> $stable(data_mask));

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_lockchk
        // R7: region contents frozen while the region lock bit is set
        a_r7_region_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            $past(lock_bits[r]) |-> ($stable(region_base[r*DATA_W +: DATA_W]) &&
                                     $stable(region_sren[r*DATA_W +: DATA_W]) &&
                                     $stable(region_iv[r*2*DATA_W +: 2*DATA_W])));
    end

    // R9: unmapped read returns zero and flags the error bit
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rd_data == '0 && err_q[0]));

    // R11: zero written to the error register clears it
    a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == ADDR_W'(A_ERR) && wdata == '0) |=> (err_q == '0));

    // R12: read data holds between reads
    a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind enc_regs enc_regs_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_REGIONS (NUM_REGIONS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rd_data     (rd_data),
    .enc_en      (enc_en),
    .data_mask   (data_mask),
    .lock_bits   (lock_bits),
    .region_base (region_base),
    .region_sren (region_sren),
    .region_iv   (region_iv),
    .err_q       (err_q),
    .unmapped    (unmapped)
);

// File: tb/enc_regs_bench.sv
module enc_regs_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rd_data;
    logic         enc_en;
    logic [63:0]  data_mask;
    logic [8:0]   lock_bits;
    logic [95:0]  region_base;
    logic [95:0]  region_sren;
    logic [191:0] region_iv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    enc_regs u_enc_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rd_data     (rd_data),
        .enc_en      (enc_en),
        .data_mask   (data_mask),
        .lock_bits   (lock_bits),
        .region_base (region_base),
        .region_sren (region_sren),
        .region_iv   (region_iv)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [7:0] ra(input int r, input int f);
        return 8'(8'h10 + 4 * r + f);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 enc_en", 64'(enc_en), 64'h0);
        chk("R1 mask", data_mask, 64'h0);
        chk("R1 lock", 64'(lock_bits), 64'h0);
        chk("R1 base", 64'(region_base[95:32]) | 64'(region_base[31:0]), 64'h0);
        chk("R1 iv", region_iv[63:0] | region_iv[127:64] | region_iv[191:128], 64'h0);
        rd(8'h04, v); chk("R1 err", 64'(v), 64'h0);
        rd(ra(2, 1), v); chk("R1 sren2", 64'(v), 64'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R2 enc_en set", 64'(enc_en), 64'h1);
        rd(8'h00, v); chk("R2 readback", 64'(v), 64'h1);
        wr(8'h00, 32'hFFFF_FFFE);
        chk("R2 enc_en clear", 64'(enc_en), 64'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(8'h01, 32'h1234_5678);
        wr(8'h02, 32'h9ABC_DEF0);
        chk("R3 mask out", data_mask, 64'h9ABC_DEF0_1234_5678);
        rd(8'h01, v); chk("R3 lo read", 64'(v), 64'h1234_5678);
        rd(8'h02, v); chk("R3 hi read", 64'(v), 64'h9ABC_DEF0);
    endtask

    task automatic t_regions();
        logic [31:0] v;
        for (int r = 0; r < 3; r++) begin
            for (int f = 0; f < 4; f++) begin
                wr(ra(r, f), 32'hA000_0000 + 32'(r * 16 + f));
            end
        end
        for (int r = 0; r < 3; r++) begin
            chk("R4 base out", 64'(region_base[r*32 +: 32]), 64'hA000_0000 + 64'(r * 16));
            chk("R4 sren out", 64'(region_sren[r*32 +: 32]), 64'hA000_0001 + 64'(r * 16));
            chk("R4 iv out", region_iv[r*64 +: 64],
                {32'hA000_0003 + 32'(r * 16), 32'hA000_0002 + 32'(r * 16)});
            for (int f = 0; f < 4; f++) begin
                rd(ra(r, f), v);
                chk("R4 readback", 64'(v), 64'hA000_0000 + 64'(r * 16 + f));
            end
        end
    endtask

    task automatic t_timing();
        logic [31:0] v;
        rd(ra(1, 2), v);
        chk("R12 read due", 64'(v), 64'hA000_0012);
        addr = 8'h00;
        repeat (3) @(negedge clk);
        chk("R12 held", 64'(rd_data), 64'hA000_0012);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(8'h07, v); chk("R9 unmapped read zero", 64'(v), 64'h0);
        rd(8'h04, v); chk("R9 err set", 64'(v), 64'h1);
        wr(8'h04, 32'h0);
        rd(8'h04, v); chk("R11 clear", 64'(v), 64'h0);
        rd(8'h1C, v); chk("R9 past regions zero", 64'(v), 64'h0);
        wr(8'h04, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R10 err set", 64'(v), 64'h1);
        chk("R10 mask untouched", data_mask, 64'h9ABC_DEF0_1234_5678);
        chk("R10 enable untouched", 64'(enc_en), 64'h0);
        wr(8'h04, 32'h5);
        rd(8'h04, v); chk("R11 nonzero keeps", 64'(v), 64'h1);
        wr(8'h04, 32'h0);
        rd(8'h04, v); chk("R11 clear again", 64'(v), 64'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(8'h03, 32'hFFFF_FE02);
        rd(8'h03, v); chk("R5 high bits dropped", 64'(v), 64'h2);
        wr(ra(1, 0), 32'hDEAD_0000);
        wr(ra(1, 3), 32'hDEAD_0003);
        chk("R7 base1 kept", 64'(region_base[63:32]), 64'hA000_0010);
        rd(ra(1, 3), v); chk("R7 ivhi1 read", 64'(v), 64'hA000_0013);
        wr(ra(0, 0), 32'h0000_BEEF);
        chk("R7 region0 open", 64'(region_base[31:0]), 64'h0000_BEEF);
        wr(8'h03, 32'h0);
        chk("R6 zero write", 64'(lock_bits), 64'h002);
        wr(8'h03, 32'h0F8);
        rd(8'h03, v); chk("R5 bits 3..7 dropped", 64'(v), 64'h2);
        wr(8'h03, 32'h100);
        chk("R5 mask bit", 64'(lock_bits), 64'h102);
        wr(8'h01, 32'h0);
        wr(8'h02, 32'h0);
        chk("R8 mask kept", data_mask, 64'h9ABC_DEF0_1234_5678);
        rd(8'h02, v); chk("R8 hi read", 64'(v), 64'h9ABC_DEF0);
        wr(8'h03, 32'h005);
        wr(ra(0, 1), 32'h0);
        wr(ra(2, 2), 32'h0);
        chk("R7 sren0 kept", 64'(region_sren[31:0]), 64'hA000_0001);
        chk("R7 ivlo2 kept", region_iv[191:128], 64'hA000_0023_A000_0022);
        chk("R6 all set", 64'(lock_bits), 64'h107);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_mask();
        t_regions();
        t_timing();
        t_unmapped();
        t_lock();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule